// File: doc/BRIEF.md
# Prescaled Programmable Clock-Rate Generator

This block makes a slower clock from a chosen source clock. It divides the source by a count held in one control register. An optional fixed divide-by-16 stage can sit in front of the counter. The source can be the system clock or one of two external clock pins. Each external pin is synchronised into the system clock domain, and each rising edge on it counts as one source tick.

The block has two outputs. The first is a one-cycle rate pulse, given once per division period. The second is a square-wave clock that toggles on every rate pulse, so its period is twice the division. Host software works out the division for a wanted rate and writes it in a single register write. If the wanted division D is above 4096, software sets the prescale bit and stores D/16-1. Otherwise it clears the prescale bit and stores D-1.

Two separate control bits stop the generator. The reset bit holds the divider at its starting phase, and clearing it restarts the divider from that phase. Clearing the enable bit idles the outputs, and the register keeps its contents.

Top module: `prescaled_rate_gen`

## Requirements
- R1: After reset, `rdData` reads 0 and both outputs are low. `rdData` always returns the last word written, with all 17 bits in place. The control word layout is: bit 0 prescale, bits 12:1 count N, bits 14:13 source select, bit 15 enable, bit 16 software reset.
- R2: With the internal source, the prescale bit clear and count N, `rateTick` pulses for one cycle every N+1 system cycles. N=0 gives a pulse on every cycle.
- R3: With the prescale bit set, the interval between pulses is 16*(N+1) source ticks. So a division of 4800, stored as prescale=1 and N=299, gives 4800 cycles.
- R4: `rateClk` toggles in the same cycle as each `rateTick` and holds its level in every other cycle while running. Its period is therefore 2*(N+1)*prescale source ticks.
- R5: Source select 1 counts rising edges of `extClkA` only. Source select 2 counts rising edges of `extClkB` only. The pin that is not selected has no effect on the interval.
- R6: Source select 3 behaves as the internal source, the same as select 0.
- R7: While the software reset bit is set, both outputs stay low. After the bit is cleared, with enable set and the internal source, the first pulse appears N+1 cycles after the write edge (16*(N+1) with the prescale bit set).
- R8: While the enable bit is clear, both outputs stay low and the register keeps its contents. Setting enable again restarts the divider from the same starting phase as R7.
- R9: A new count written while the generator runs does not cut short the period in progress. That period ends with the old count, and the following period uses the new count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the internal source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control register |
| wrData | input | CNT_W+5 | Control word to write |
| rdData | output | CNT_W+5 | Current control register contents |
| extClkA | input | 1 | External source clock, select value 1 |
| extClkB | input | 1 | External source clock, select value 2 |
| rateTick | output | 1 | One-cycle pulse at the end of each division period |
| rateClk | output | 1 | Square wave that toggles on each rate pulse |

## Verification
The bench tries random counts with random prescale and source choices. The two external pins run at different periods, 4 and 6 cycles, so a measured interval shows which pin was counted and whether the other one leaked in. Directed cases cover:
- N=0, which gives back-to-back pulses.
- A division above 4096, which shows that the prescaled encoding really gives 16*(N+1).
- The reserved select value, which must not look like either external pin.
- The first-pulse latency after a reset release or a re-enable, which separates a clean restart from a phase carried over from the old run.
- A count change in mid-period, which separates an update at the next reload from an immediate one.

// File: rtl/rgen_pkg.sv
package rgen_pkg;

  // Source select encoding (control word bits CNT_W+2:CNT_W+1)
  typedef enum logic [1:0] {
    SRC_INT   = 2'd0,
    SRC_EXT_A = 2'd1,
    SRC_EXT_B = 2'd2,
    SRC_RSVD  = 2'd3
  } src_sel_t;

  // Strobes sent from the control side to the divider datapath
  typedef struct packed {
    logic active;   // enable set and software reset clear
    logic srcTick;  // one source tick this cycle
    logic div16;    // prescale stage in use
  } rate_strobe_t;

endpackage

// File: rtl/rgen_ctrl.sv
module rgen_ctrl
  import rgen_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [CNT_W+4:0]   wrData,
  output logic [CNT_W+4:0]   rdData,
  input  logic               extClkA,
  input  logic               extClkB,
  output rate_strobe_t       strobe,
  output logic [CNT_W-1:0]   reloadVal
);
  localparam int REG_W   = CNT_W + 5;
  localparam int POS_PRE = 0;
  localparam int POS_SRC = CNT_W + 1;
  localparam int POS_EN  = CNT_W + 3;
  localparam int POS_RST = CNT_W + 4;
  localparam int NUM_EXT = 2;

  logic [REG_W-1:0]   ctrlReg;
  logic [NUM_EXT-1:0] extPins;
  logic [NUM_EXT-1:0] extRise;
  src_sel_t           srcSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlReg <= '0;
    else if (wrEn) ctrlReg <= wrData;
  end

  assign rdData  = ctrlReg;
  assign extPins = {extClkB, extClkA};

  // Two-flop synchroniser plus an edge history flop for each external pin
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_sync
    logic [2:0] shiftReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shiftReg <= '0;
      else       shiftReg <= {shiftReg[1:0], extPins[g]};
    end
    assign extRise[g] = shiftReg[1] & ~shiftReg[2];
  end

  assign srcSel = src_sel_t'(ctrlReg[POS_SRC+1:POS_SRC]);

  always_comb begin
    strobe.active = ctrlReg[POS_EN] & ~ctrlReg[POS_RST];
    strobe.div16  = ctrlReg[POS_PRE];
    unique case (srcSel)
      SRC_EXT_A: strobe.srcTick = extRise[0];
      SRC_EXT_B: strobe.srcTick = extRise[1];
      default:   strobe.srcTick = 1'b1;  // internal and reserved
    endcase
  end

  assign reloadVal = ctrlReg[CNT_W:1];

  // R5: an external pin yields isolated ticks, never two in a row
  p_ext_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((srcSel == SRC_EXT_A || srcSel == SRC_EXT_B) && srcSel == $past(srcSel)
      && $past(strobe.srcTick)) |-> !strobe.srcTick);

endmodule

// File: rtl/rgen_dp.sv
module rgen_dp
  import rgen_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PRE_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rate_strobe_t     strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             rateTick,
  output logic             rateClk
);
  localparam int PRE_W = $clog2(PRE_DIV);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] mainCnt;
  logic [CNT_W-1:0] effCnt;
  logic             fresh;
  logic             preWrap;
  logic             stageTick;
  logic             reloadNow;

  assign preWrap   = (preCnt == PRE_W'(PRE_DIV - 1));
  assign stageTick = strobe.srcTick & (~strobe.div16 | preWrap);
  // The first active cycle takes the count straight from the register
  assign effCnt    = fresh ? reloadVal : mainCnt;
  assign reloadNow = stageTick & (effCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      mainCnt  <= '0;
      fresh    <= 1'b1;
      rateTick <= 1'b0;
      rateClk  <= 1'b0;
    end else if (!strobe.active) begin
      preCnt   <= '0;
      fresh    <= 1'b1;
      rateTick <= 1'b0;
      rateClk  <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (strobe.srcTick && strobe.div16)
        preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (stageTick)
        mainCnt <= reloadNow ? reloadVal : effCnt - 1'b1;
      else
        mainCnt <= effCnt;
      rateTick <= reloadNow;
      if (reloadNow) rateClk <= ~rateClk;
    end
  end

  // R8 (and R7): an idle generator drives both outputs low next cycle
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.active |=> (!rateTick && !rateClk));

  // R4: every pulse coincides with a change of the clock output
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rstN)
    rateTick |-> (rateClk != $past(rateClk)));

  // R4: between pulses a running clock output holds its level
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.active) && !rateTick) |-> $stable(rateClk));

  // R2: no pulse without a source tick in the cycle before
  p_no_tick_wo_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.active) && !$past(strobe.srcTick)) |-> !rateTick);

endmodule

// File: rtl/prescaled_rate_gen.sv
module prescaled_rate_gen
  import rgen_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int PRE_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CNT_W+4:0] wrData,
  output logic [CNT_W+4:0] rdData,
  input  logic             extClkA,
  input  logic             extClkB,
  output logic             rateTick,
  output logic             rateClk
);
  rate_strobe_t     strobe;
  logic [CNT_W-1:0] reloadVal;

  rgen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .extClkA   (extClkA),
    .extClkB   (extClkB),
    .strobe    (strobe),
    .reloadVal (reloadVal)
  );

  rgen_dp #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reloadVal (reloadVal),
    .rateTick  (rateTick),
    .rateClk   (rateClk)
  );

endmodule

// File: tb/prescaled_rate_gen_tb.sv
`timescale 1ns/1ps
module prescaled_rate_gen_tb;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [CNT_W+4:0] wrData = '0;
  logic [CNT_W+4:0] rdData;
  logic             extClkA = 1'b0;
  logic             extClkB = 1'b0;
  logic             rateTick;
  logic             rateClk;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  int extCntA = 0;
  int extCntB = 0;

  prescaled_rate_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .extClkA(extClkA), .extClkB(extClkB), .rateTick(rateTick), .rateClk(rateClk)
  );

  always #2.5 clk = ~clk;  // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  // extClkA period 4 cycles, extClkB period 6 cycles
  always @(negedge clk) begin
    extCntA <= (extCntA == 1) ? 0 : extCntA + 1;
    if (extCntA == 1) extClkA <= ~extClkA;
    extCntB <= (extCntB == 2) ? 0 : extCntB + 1;
    if (extCntB == 2) extClkB <= ~extClkB;
  end

  function automatic logic [CNT_W+4:0] mkWord(bit p, int n, int sel, bit en, bit rst);
    return {rst, en, 2'(sel), CNT_W'(n), p};
  endfunction

  function automatic int expIv(bit p, int n, int sel);
    int srcPer = (sel == 1) ? 4 : (sel == 2) ? 6 : 1;
    return (n + 1) * (p ? 16 : 1) * srcPer;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [CNT_W+4:0] w);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTick(output int t, output bit clkOk);
    bit prevC = rateClk;
    int guard = 0;
    clkOk = 1'b1;
    do begin
      @(negedge clk);
      guard++;
      if (!rateTick && rateClk != prevC) clkOk = 1'b0;
    end while (!rateTick && guard < 20000);
    if (rateClk == prevC) clkOk = 1'b0;
    t = cyc;
  endtask

  task automatic firstTick(output int k);
    k = 0;
    while (!rateTick && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic runTrial(bit p, int n, int sel, output int iv, output bit clkOk);
    int t0, t1;
    bit ok0;
    wr(mkWord(p, n, sel, 1'b1, 1'b1));
    wr(mkWord(p, n, sel, 1'b1, 1'b0));
    waitTick(t0, ok0);
    waitTick(t1, clkOk);
    iv = t1 - t0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int iv, k, t0, t1, seedDummy;
    bit ok;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rdData after reset", int'(rdData), 0);
    chk("R1", "rateTick after reset", int'(rateTick), 0);
    chk("R1", "rateClk after reset", int'(rateClk), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs idle with zero register", int'({rateTick, rateClk}), 0);

    // R2 N=0 back-to-back pulses
    runTrial(1'b0, 0, 0, iv, ok);
    chk("R2", "N=0 interval", iv, 1);
    chk("R4", "N=0 clock toggle", int'(ok), 1);

    // Constrained random mix (R2, R3, R5, R6, R4, R1)
    for (int i = 0; i < 20; i++) begin
      bit p = 1'($urandom_range(0, 1));
      int n = int'($urandom_range(0, 9));
      int sel = int'($urandom_range(0, 3));
      logic [CNT_W+4:0] w = mkWord(p, n, sel, 1'b1, 1'b0);
      runTrial(p, n, sel, iv, ok);
      chk("R1", "readback", int'(rdData), int'(w));
      if (sel == 1 || sel == 2) chk("R5", "external interval", iv, expIv(p, n, sel));
      else if (sel == 3)        chk("R6", "reserved-select interval", iv, expIv(p, n, sel));
      else if (p)               chk("R3", "prescaled interval", iv, expIv(p, n, sel));
      else                      chk("R2", "internal interval", iv, expIv(p, n, sel));
      chk("R4", "clock holds between pulses and toggles on pulse", int'(ok), 1);
    end

    // R5 directed: each pin alone
    runTrial(1'b0, 2, 1, iv, ok);
    chk("R5", "extClkA N=2", iv, 12);
    runTrial(1'b0, 2, 2, iv, ok);
    chk("R5", "extClkB N=2", iv, 18);
    // R6 directed
    runTrial(1'b0, 4, 3, iv, ok);
    chk("R6", "select 3 N=4", iv, 5);
    // R3 large division 4800 -> prescale, N=299
    runTrial(1'b1, 299, 0, iv, ok);
    chk("R3", "division 4800", iv, 4800);

    // R7 software reset hold then restart phase
    wr(mkWord(1'b0, 5, 0, 1'b1, 1'b1));
    @(negedge clk);
    k = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (rateTick || rateClk) k++;
    end
    chk("R7", "outputs active during reset", k, 0);
    wr(mkWord(1'b0, 5, 0, 1'b1, 1'b0));
    firstTick(k);
    chk("R7", "first pulse latency N=5", k, 6);
    wr(mkWord(1'b1, 1, 0, 1'b1, 1'b1));
    wr(mkWord(1'b1, 1, 0, 1'b1, 1'b0));
    firstTick(k);
    chk("R7", "first pulse latency prescaled N=1", k, 32);

    // R8 enable clear keeps configuration
    wr(mkWord(1'b0, 7, 0, 1'b0, 1'b0));
    @(negedge clk);
    k = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (rateTick || rateClk) k++;
    end
    chk("R8", "outputs active while disabled", k, 0);
    chk("R8", "register kept while disabled", int'(rdData), int'(mkWord(1'b0, 7, 0, 1'b0, 1'b0)));
    wr(mkWord(1'b0, 7, 0, 1'b1, 1'b0));
    firstTick(k);
    chk("R8", "first pulse after re-enable N=7", k, 8);

    // R9 count change mid-period takes effect at next reload
    runTrial(1'b0, 10, 0, iv, ok);
    waitTick(t0, ok);
    wr(mkWord(1'b0, 3, 0, 1'b1, 1'b0));
    waitTick(t1, ok);
    chk("R9", "period in progress keeps old count", t1 - t0, 11);
    waitTick(t0, ok);
    chk("R9", "following period uses new count", t0 - t1, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule